// File: doc/BRIEF.md
# Chained DMA Tag Engine

This block is the front end of one DMA channel. When software starts the channel, the block picks one of two modes. In normal mode it hands a single programmed block to a data mover. In chain mode it walks a linked list of 128-bit descriptors ("tags") held in memory. For each tag it loads the payload address and quadword count and applies stall control against a drain-side address limit. It can also send the tag's upper half into the data stream. It then starts the mover on the payload and decides whether the chain continues or ends.

The payload path is outside the block. The mover receives an address and a quadword count on `mv_start` and reports back with `mv_done`. Tags are fetched through a simple request/response port. After each tag the next tag address moves forward by 16 bytes. Certain tag IDs, or a tag interrupt flag combined with the channel's interrupt enable, close the chain. The block raises a one-cycle completion pulse when the channel finishes.

The engine is a single state machine:
- **IDLE**: waits for `go`. A nonzero count leads to XFER_GO and a zero count leads to FETCH.
- **FETCH**: requests a tag while `dma_en` is high and moves to DECODE on `tag_valid`.
- **DECODE**: moves to STALL on a stall hit. Otherwise it moves to FWD, XFER_GO, FETCH or FINISH.
- **STALL**: waits until the stall condition clears, then continues as DECODE would.
- **FWD**: forwards the tag's upper half, then moves to XFER_GO, FETCH or FINISH.
- **XFER_GO**: pulses `mv_start` and moves to XFER_WAIT.
- **XFER_WAIT**: on `mv_done`, moves to FINISH if the chain is done and to FETCH otherwise.
- **FINISH**: pulses `done_irq` and returns to IDLE.

Top module: `dmac_chain_engine`

## Requirements
- R1: After reset `busy`, `tag_req`, `mv_start`, `fwd_valid`, `stall_irq` and `done_irq` are low and `fifo_level` is 0.
- R2: A `go` with nonzero `prog_qwc` and either `chain_mode` low or `dir_from_mem` low starts exactly one transfer at `prog_madr`/`prog_qwc`. It fetches no tag and then completes.
- R3: A `go` with zero `prog_qwc` fetches the first tag from `prog_tadr`, and each later tag from the previous tag address plus 16. Tag layout: bits [15:0] hold the quadword count, bits [30:28] hold the ID, bit 31 is the IRQ flag, bits [63:32] hold the payload address and bits [127:64] are the upper half.
- R4: Each tag with a nonzero count produces one `mv_start` carrying the tag's address and count. A tag with a zero count produces none.
- R5: Tag ID 0 (reference-then-end) and ID 7 (end) close the chain after that tag's block. The other IDs continue to the next tag.
- R6: A tag with the IRQ flag set closes the chain only when `tie_en` is high. With `tie_en` low the chain continues.
- R7: When `stall_sel` is high, the tag ID is 4 (reference-with-stall) and address + 16 × count ≥ `stall_addr`, the block pulses `stall_irq` once. It starts no transfer until the condition clears.
- R8: With `tte_en` high, every fetched tag gives one `fwd_valid` pulse before its transfer. `fwd_data` carries the tag's bits [127:64] in its upper half and zero in its lower half.
- R9: With `chain_mode` and `dir_from_mem` high and nonzero `prog_qwc`, the preloaded block is transferred first. The chain is done right away if `pre_tag_id` is 0 or 7, or if `pre_tag_irq` and `tie_en` are both high. Otherwise tag fetching continues from `prog_tadr`.
- R10: While a block is pending, `fifo_level` equals min(16, remaining count) when `dir_from_mem` was high at start, and 0 otherwise.
- R11: Completion gives one cycle of `done_irq` while `busy` is high. `busy` is low on the next cycle.
- R12: While `dma_en` is low the engine issues no tag request and holds its state. It resumes when `dma_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dma_en | input | 1 | Global DMA enable |
| go | input | 1 | Start pulse, taken in IDLE |
| chain_mode | input | 1 | Channel configured for chain operation |
| dir_from_mem | input | 1 | Transfer direction is read-from-memory |
| tte_en | input | 1 | Forward tag upper half into data stream |
| tie_en | input | 1 | Tag interrupt enable |
| prog_qwc | input | QWC_W | Programmed quadword count |
| prog_madr | input | ADDR_W | Programmed data address |
| prog_tadr | input | ADDR_W | Programmed tag address |
| pre_tag_id | input | 3 | ID of the preloaded tag |
| pre_tag_irq | input | 1 | IRQ flag of the preloaded tag |
| stall_sel | input | 1 | Stall control selects this channel |
| stall_addr | input | ADDR_W | Drain stall address limit |
| tag_req | output | 1 | Tag read request |
| tag_addr | output | ADDR_W | Tag read address |
| tag_valid | input | 1 | Tag read response valid |
| tag_data | input | 128 | Tag read response data |
| fwd_valid | output | 1 | Forwarded tag word valid |
| fwd_data | output | 128 | Forwarded tag word |
| mv_start | output | 1 | Start payload transfer |
| mv_addr | output | ADDR_W | Payload address |
| mv_qwc | output | QWC_W | Payload quadword count |
| mv_done | input | 1 | Payload transfer finished |
| fifo_level | output | LVL_W | Occupancy report |
| stall_irq | output | 1 | Stall interrupt pulse |
| done_irq | output | 1 | Channel completion pulse |
| busy | output | 1 | Channel active (start bit) |

## Verification
The hardest state to reach from the ports is a held stall. It needs a reference-with-stall tag, stall control pointed at this channel, and a drain limit placed exactly at the end of the block. A directed chain sets the limit equal to address + 16 × count and waits, which checks that only one stall pulse appears and no transfer starts. It then raises the limit by one byte to release the stall, and in a second run starts with the limit already one byte past the end. Random chains of mixed IDs, counts (including zero), IRQ flags and forwarding settings are compared against a bench-side walk of the same tag memory.

// File: rtl/dmac_chain_pkg.sv
package dmac_chain_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_STALL,
        S_FWD,
        S_XFER_GO,
        S_XFER_WAIT,
        S_FINISH
    } chain_state_e;

    localparam logic [2:0] TID_REF_END  = 3'd0;
    localparam logic [2:0] TID_REF_STALL = 3'd4;
    localparam logic [2:0] TID_END      = 3'd7;

    localparam int TAG_STEP = 16;

endpackage

// File: rtl/dmac_tag_decode.sv
module dmac_tag_decode
    import dmac_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int QWC_W  = 16
) (
    input  logic [63:0]       tag_lo,
    output logic [QWC_W-1:0]  qwc,
    output logic [2:0]        id,
    output logic              irq,
    output logic [ADDR_W-1:0] addr,
    output logic              ends_chain
);
    logic unused_rsvd;

    assign qwc        = tag_lo[QWC_W-1:0];
    assign id         = tag_lo[30:28];
    assign irq        = tag_lo[31];
    assign addr       = tag_lo[32 +: ADDR_W];
    assign ends_chain = (id == TID_REF_END) || (id == TID_END);
    assign unused_rsvd = ^tag_lo[27:QWC_W];
endmodule

// File: rtl/dmac_stall_cmp.sv
module dmac_stall_cmp #(
    parameter int ADDR_W = 32,
    parameter int QWC_W  = 16
) (
    input  logic [ADDR_W-1:0] madr,
    input  logic [QWC_W-1:0]  qwc,
    input  logic [ADDR_W-1:0] limit,
    output logic              reach
);
    localparam int SPAN_W = QWC_W + 4;
    localparam int EXT_W  = ((ADDR_W > SPAN_W) ? ADDR_W : SPAN_W) + 1;

    logic [EXT_W-1:0] end_ptr;

    assign end_ptr = EXT_W'(madr) + EXT_W'({qwc, 4'b0000});
    assign reach   = end_ptr >= EXT_W'(limit);
endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine
    import dmac_chain_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int QWC_W    = 16,
    parameter int FIFO_MAX = 16,
    localparam int LVL_W   = $clog2(FIFO_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              go,
    input  logic              chain_mode,
    input  logic              dir_from_mem,
    input  logic              tte_en,
    input  logic              tie_en,
    input  logic [QWC_W-1:0]  prog_qwc,
    input  logic [ADDR_W-1:0] prog_madr,
    input  logic [ADDR_W-1:0] prog_tadr,
    input  logic [2:0]        pre_tag_id,
    input  logic              pre_tag_irq,
    input  logic              stall_sel,
    input  logic [ADDR_W-1:0] stall_addr,
    output logic              tag_req,
    output logic [ADDR_W-1:0] tag_addr,
    input  logic              tag_valid,
    input  logic [127:0]      tag_data,
    output logic              fwd_valid,
    output logic [127:0]      fwd_data,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [QWC_W-1:0]  mv_qwc,
    input  logic              mv_done,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              stall_irq,
    output logic              done_irq,
    output logic              busy
);
    chain_state_e state_q, state_d;

    logic [ADDR_W-1:0] cur_madr, tadr_q;
    logic [QWC_W-1:0]  cur_qwc;
    logic [63:0]       tag_hi_q;
    logic [2:0]        id_q;
    logic              done_q, dir_q, tte_q, tie_q;

    logic [QWC_W-1:0]  dec_qwc;
    logic [2:0]        dec_id;
    logic              dec_irq, dec_ends, reach, stall_hit, pre_done;
    logic [ADDR_W-1:0] dec_addr;
    chain_state_e      body_next, check_next;

    dmac_tag_decode #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_dec (
        .tag_lo     (tag_data[63:0]),
        .qwc        (dec_qwc),
        .id         (dec_id),
        .irq        (dec_irq),
        .addr       (dec_addr),
        .ends_chain (dec_ends)
    );

    dmac_stall_cmp #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_stall (
        .madr  (cur_madr),
        .qwc   (cur_qwc),
        .limit (stall_addr),
        .reach (reach)
    );

    assign stall_hit = stall_sel && (id_q == TID_REF_STALL) && reach;
    assign pre_done  = !(chain_mode && dir_from_mem)
                     || (pre_tag_id == TID_REF_END) || (pre_tag_id == TID_END)
                     || (pre_tag_irq && tie_en);

    // Where to go once the tag is fully accepted (after stall / forward)
    always_comb begin
        if (cur_qwc != '0)  body_next = S_XFER_GO;
        else if (done_q)    body_next = S_FINISH;
        else                body_next = S_FETCH;
        check_next = tte_q ? S_FWD : body_next;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (go) state_d = (prog_qwc != '0) ? S_XFER_GO : S_FETCH;
            S_FETCH:     if (tag_valid) state_d = S_DECODE;
            S_DECODE:    state_d = stall_hit ? S_STALL : check_next;
            S_STALL:     if (!stall_hit) state_d = check_next;
            S_FWD:       state_d = body_next;
            S_XFER_GO:   state_d = S_XFER_WAIT;
            S_XFER_WAIT: if (mv_done) state_d = done_q ? S_FINISH : S_FETCH;
            S_FINISH:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Channel context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_madr <= '0;
            cur_qwc  <= '0;
            tadr_q   <= '0;
            tag_hi_q <= '0;
            id_q     <= '0;
            done_q   <= 1'b0;
            dir_q    <= 1'b0;
            tte_q    <= 1'b0;
            tie_q    <= 1'b0;
        end else if (state_q == S_IDLE && go) begin
            cur_madr <= prog_madr;
            cur_qwc  <= prog_qwc;
            tadr_q   <= prog_tadr;
            id_q     <= '0;
            dir_q    <= dir_from_mem;
            tte_q    <= tte_en;
            tie_q    <= tie_en;
            done_q   <= (prog_qwc != '0) && pre_done;
        end else if (state_q == S_FETCH && tag_valid) begin
            cur_madr <= dec_addr;
            cur_qwc  <= dec_qwc;
            tag_hi_q <= tag_data[127:64];
            id_q     <= dec_id;
            tadr_q   <= tadr_q + ADDR_W'(TAG_STEP);
            done_q   <= done_q || dec_ends || (dec_irq && tie_q);
        end else if (state_q == S_XFER_WAIT && mv_done) begin
            cur_qwc  <= '0;
        end else if (state_q == S_FINISH) begin
            done_q   <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        tag_req    = (state_q == S_FETCH) && dma_en;
        tag_addr   = tadr_q;
        fwd_valid  = (state_q == S_FWD);
        fwd_data   = {tag_hi_q, 64'd0};
        mv_start   = (state_q == S_XFER_GO);
        mv_addr    = cur_madr;
        mv_qwc     = cur_qwc;
        stall_irq  = (state_q == S_DECODE) && stall_hit;
        done_irq   = (state_q == S_FINISH);
        busy       = (state_q != S_IDLE);
        if (!dir_q)                            fifo_level = '0;
        else if (cur_qwc >= QWC_W'(FIFO_MAX))  fifo_level = LVL_W'(FIFO_MAX);
        else                                   fifo_level = LVL_W'(cur_qwc);
    end
endmodule

// File: rtl/dmac_chain_checks.sv
module dmac_chain_checks #(
    parameter int QWC_W    = 16,
    parameter int FIFO_MAX = 16,
    parameter int LVL_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_en,
    input logic             tag_req,
    input logic             fwd_valid,
    input logic [127:0]     fwd_data,
    input logic             mv_start,
    input logic [QWC_W-1:0] mv_qwc,
    input logic [LVL_W-1:0] fifo_level,
    input logic             stall_irq,
    input logic             done_irq,
    input logic             busy
);
    a_r12_no_fetch_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !tag_req);

    a_r8_fwd_lower_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_data[63:0] == 64'd0));

    a_r4_no_empty_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> (mv_qwc != '0));

    a_r10_level_capped: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_MAX));

    a_r11_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> busy);

    a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !busy);

    a_r7_stall_blocks_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        stall_irq |=> !mv_start);

    a_r7_single_stall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stall_irq |=> !stall_irq);

    a_r2_one_action_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tag_req, fwd_valid, mv_start, done_irq}));
endmodule

bind dmac_chain_engine dmac_chain_checks #(
    .QWC_W(QWC_W), .FIFO_MAX(FIFO_MAX), .LVL_W(LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_en     (dma_en),
    .tag_req    (tag_req),
    .fwd_valid  (fwd_valid),
    .fwd_data   (fwd_data),
    .mv_start   (mv_start),
    .mv_qwc     (mv_qwc),
    .fifo_level (fifo_level),
    .stall_irq  (stall_irq),
    .done_irq   (done_irq),
    .busy       (busy)
);

// File: tb/sim_dmac_chain_engine.sv
module sim_dmac_chain_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int QWC_W  = 16;
    localparam int LVL_W  = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dma_en = 1'b1, go = 1'b0, chain_mode = 1'b0, dir_from_mem = 1'b0;
    logic tte_en = 1'b0, tie_en = 1'b0, pre_tag_irq = 1'b0, stall_sel = 1'b0;
    logic [QWC_W-1:0]  prog_qwc = '0;
    logic [ADDR_W-1:0] prog_madr = '0, prog_tadr = '0, stall_addr = '0;
    logic [2:0]        pre_tag_id = '0;
    logic              tag_req, tag_valid = 1'b0, fwd_valid, mv_start, mv_done = 1'b0;
    logic [ADDR_W-1:0] tag_addr, mv_addr;
    logic [127:0]      tag_data = '0, fwd_data;
    logic [QWC_W-1:0]  mv_qwc;
    logic [LVL_W-1:0]  fifo_level;
    logic              stall_irq, done_irq, busy;

    dmac_chain_engine u0 (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .go(go),
        .chain_mode(chain_mode), .dir_from_mem(dir_from_mem),
        .tte_en(tte_en), .tie_en(tie_en), .prog_qwc(prog_qwc),
        .prog_madr(prog_madr), .prog_tadr(prog_tadr),
        .pre_tag_id(pre_tag_id), .pre_tag_irq(pre_tag_irq),
        .stall_sel(stall_sel), .stall_addr(stall_addr),
        .tag_req(tag_req), .tag_addr(tag_addr), .tag_valid(tag_valid),
        .tag_data(tag_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .mv_start(mv_start), .mv_addr(mv_addr), .mv_qwc(mv_qwc),
        .mv_done(mv_done), .fifo_level(fifo_level), .stall_irq(stall_irq),
        .done_irq(done_irq), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    logic [127:0] tag_mem [0:31];
    logic [ADDR_W-1:0] lg_addr [0:31];
    logic [QWC_W-1:0]  lg_qwc  [0:31];
    logic [127:0]      lg_fwd  [0:31];
    logic [ADDR_W-1:0] ex_addr [0:31];
    logic [QWC_W-1:0]  ex_qwc  [0:31];
    logic [127:0]      ex_fwd  [0:31];
    int n_mv = 0, n_fwd = 0, n_stall = 0, n_done = 0, n_req = 0, mv_delay = 0;
    int e_mv = 0, e_fwd = 0;
    logic cfg_dir = 1'b0, prev_done = 1'b0;

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_tag(input bit irq, input logic [2:0] id,
            input logic [15:0] qwc, input logic [31:0] addr, input logic [63:0] hi);
        return {hi, addr, irq, id, 12'd0, qwc};
    endfunction

    // Tag memory model and mover model, both reacting at the falling edge
    always @(negedge clk) begin
        if (tag_req && !tag_valid) begin
            tag_valid <= 1'b1;
            tag_data  <= tag_mem[tag_addr[8:4]];
        end else begin
            tag_valid <= 1'b0;
        end
        if (tag_req) n_req++;
        mv_done <= 1'b0;
        if (mv_start) begin
            if (n_mv < 32) begin lg_addr[n_mv] = mv_addr; lg_qwc[n_mv] = mv_qwc; end
            n_mv++;
            chk(fifo_level == (cfg_dir ? ((mv_qwc > 16) ? 5'd16 : 5'(mv_qwc)) : 5'd0),
                "R10 fifo level", 128'(fifo_level),
                128'(cfg_dir ? ((mv_qwc > 16) ? 16 : mv_qwc) : 0));
            mv_delay <= 2;
        end else if (mv_delay > 0) begin
            if (mv_delay == 1) mv_done <= 1'b1;
            mv_delay <= mv_delay - 1;
        end
        if (fwd_valid) begin
            if (n_fwd < 32) lg_fwd[n_fwd] = fwd_data;
            n_fwd++;
        end
        if (stall_irq) n_stall++;
        if (prev_done) chk(!busy, "R11 busy cleared after done", 128'(busy), 128'(0));
        if (done_irq) begin
            chk(busy, "R11 done while busy", 128'(busy), 128'(1));
            n_done++;
        end
        prev_done = done_irq;
    end

    task automatic start_op(input logic [15:0] qwc, input logic [31:0] madr,
            input logic [31:0] tadr, input bit chain, input bit dir, input bit tte,
            input bit tie, input logic [2:0] pid, input bit pirq);
        @(negedge clk);
        n_mv = 0; n_fwd = 0; n_stall = 0; n_req = 0;
        prog_qwc = qwc; prog_madr = madr; prog_tadr = tadr; chain_mode = chain;
        dir_from_mem = dir; tte_en = tte; tie_en = tie; pre_tag_id = pid;
        pre_tag_irq = pirq; cfg_dir = dir; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done(input int d0, input string rq);
        for (int i = 0; i < 3000 && n_done == d0; i++) @(negedge clk);
        chk(n_done == d0 + 1, rq, 128'(n_done), 128'(d0 + 1));
        @(negedge clk);
    endtask

    // Bench-side walk of the chain, built from the requirement text
    task automatic expect_walk(input logic [15:0] qwc, input logic [31:0] madr,
            input logic [31:0] tadr, input bit chain, input bit dir, input bit tte,
            input bit tie, input logic [2:0] pid, input bit pirq);
        logic [31:0] t;
        logic [127:0] tg;
        e_mv = 0; e_fwd = 0;
        if (qwc != 0) begin
            ex_addr[e_mv] = madr; ex_qwc[e_mv] = qwc; e_mv++;
            if (!(chain && dir) || pid == 3'd0 || pid == 3'd7 || (pirq && tie)) return;
        end
        t = tadr;
        for (int k = 0; k < 16; k++) begin
            tg = tag_mem[t[8:4]];
            if (tte) begin ex_fwd[e_fwd] = {tg[127:64], 64'd0}; e_fwd++; end
            if (tg[15:0] != 0) begin ex_addr[e_mv] = tg[63:32]; ex_qwc[e_mv] = tg[15:0]; e_mv++; end
            if (tg[30:28] == 3'd0 || tg[30:28] == 3'd7 || (tg[31] && tie)) break;
            t = t + 32'd16;
        end
    endtask

    task automatic compare(input string rq);
        chk(n_mv == e_mv, {rq, " R4 transfer count"}, 128'(n_mv), 128'(e_mv));
        for (int i = 0; i < e_mv && i < n_mv; i++) begin
            chk(lg_addr[i] == ex_addr[i], {rq, " R4 address"}, 128'(lg_addr[i]), 128'(ex_addr[i]));
            chk(lg_qwc[i] == ex_qwc[i], {rq, " R4 count"}, 128'(lg_qwc[i]), 128'(ex_qwc[i]));
        end
        chk(n_fwd == e_fwd, {rq, " R8 forward count"}, 128'(n_fwd), 128'(e_fwd));
        for (int i = 0; i < e_fwd && i < n_fwd; i++)
            chk(lg_fwd[i] == ex_fwd[i], {rq, " R8 forward data"}, lg_fwd[i], ex_fwd[i]);
    endtask

    task automatic run(input logic [15:0] qwc, input logic [31:0] madr,
            input logic [31:0] tadr, input bit chain, input bit dir, input bit tte,
            input bit tie, input logic [2:0] pid, input bit pirq, input string rq);
        int d0;
        d0 = n_done;
        expect_walk(qwc, madr, tadr, chain, dir, tte, tie, pid, pirq);
        start_op(qwc, madr, tadr, chain, dir, tte, tie, pid, pirq);
        wait_done(d0, {rq, " R11 completion"});
        compare(rq);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int d0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) tag_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !tag_req && !mv_start && !fwd_valid && !stall_irq && !done_irq
            && fifo_level == 0, "R1 reset state",
            128'({busy, tag_req, mv_start, fwd_valid, stall_irq, done_irq, fifo_level}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2: normal mode, both ways of selecting it
        run(16'd20, 32'h4000, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R2 normal from-mem");
        chk(n_req == 0, "R2 no tag fetch", 128'(n_req), 128'(0));
        run(16'd5, 32'h4400, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, "R2 chain bit to-mem");
        chk(n_req == 0 && n_fwd == 0, "R2 no tag fetch to-mem", 128'(n_req), 128'(0));

        // R9: preload ends at once
        run(16'd3, 32'h5000, 32'h100, 1'b1, 1'b1, 1'b0, 1'b0, 3'd7, 1'b0, "R9 preload end");
        chk(n_req == 0, "R9 preload end fetches nothing", 128'(n_req), 128'(0));
        run(16'd3, 32'h5000, 32'h100, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1, "R9 preload irq+tie");
        chk(n_req == 0, "R9 preload irq fetches nothing", 128'(n_req), 128'(0));
        // R9 continue + R3 tag walk + R4 zero-count tag
        tag_mem[16] = mk_tag(1'b0, 3'd1, 16'd2, 32'h6000, 64'h1111);
        tag_mem[17] = mk_tag(1'b0, 3'd7, 16'd0, 32'h6100, 64'h2222);
        run(16'd3, 32'h5000, 32'h100, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, "R9 preload continue");
        chk(n_req == 2, "R3 two tag fetches", 128'(n_req), 128'(2));

        // R6: irq flag with and without enable; R5 end IDs
        tag_mem[0] = mk_tag(1'b1, 3'd1, 16'd4, 32'h7000, 64'hA);
        tag_mem[1] = mk_tag(1'b0, 3'd2, 16'd1, 32'h7100, 64'hB);
        tag_mem[2] = mk_tag(1'b0, 3'd7, 16'd6, 32'h7200, 64'hC);
        run(16'd0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, "R6 irq without enable");
        run(16'd0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0, "R6 irq with enable");
        chk(n_mv == 1, "R6 chain stops at irq tag", 128'(n_mv), 128'(1));
        tag_mem[0] = mk_tag(1'b0, 3'd0, 16'd9, 32'h7300, 64'hD);
        run(16'd0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R5 ref-end id");
        chk(n_req == 1, "R5 single fetch on ref-end", 128'(n_req), 128'(1));

        // R7: stall at the exact boundary, then release
        tag_mem[20] = mk_tag(1'b0, 3'd4, 16'd4, 32'h1000, 64'hE);
        tag_mem[21] = mk_tag(1'b0, 3'd7, 16'd0, 32'h0, 64'hF);
        stall_sel = 1'b1; stall_addr = 32'h1040;
        d0 = n_done;
        start_op(16'd0, 32'h0, 32'h140, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        repeat (20) @(negedge clk);
        chk(n_stall == 1, "R7 stall pulse once", 128'(n_stall), 128'(1));
        chk(n_mv == 0 && busy, "R7 transfer held", 128'(n_mv), 128'(0));
        stall_addr = 32'h1041;
        wait_done(d0, "R7 completes after release");
        chk(n_mv == 1 && n_stall == 1, "R7 one transfer after release", 128'(n_mv), 128'(1));
        run(16'd0, 32'h0, 32'h140, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R7 limit past end");
        chk(n_stall == 0, "R7 no stall past end", 128'(n_stall), 128'(0));
        tag_mem[20] = mk_tag(1'b0, 3'd1, 16'd4, 32'h1000, 64'hE);
        stall_addr = 32'h0;
        run(16'd0, 32'h0, 32'h140, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, "R7 other id");
        chk(n_stall == 0, "R7 no stall for other id", 128'(n_stall), 128'(0));
        stall_sel = 1'b0;

        // R12: global enable low holds the engine
        dma_en = 1'b0;
        d0 = n_done;
        start_op(16'd0, 32'h0, 32'h140, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        repeat (12) @(negedge clk);
        chk(n_req == 0 && n_mv == 0, "R12 no fetch while disabled", 128'(n_req), 128'(0));
        chk(busy, "R12 engine held busy", 128'(busy), 128'(1));
        dma_en = 1'b1;
        wait_done(d0, "R12 resumes");
        chk(n_mv == 1, "R12 transfer after resume", 128'(n_mv), 128'(1));

        // Random chains (R3 R4 R5 R6 R8 R9 R10)
        for (int it = 0; it < 14; it++) begin
            int len, sel;
            bit tie, irq, pre;
            logic [2:0] id;
            len = 1 + int'($urandom % 4);
            sel = int'($urandom % 3);
            tie = (sel == 2) ? 1'b1 : 1'($urandom % 2);
            for (int k = 0; k < len; k++) begin
                if (k == len - 1) begin
                    id  = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd7 : 3'(1 + $urandom % 6);
                    irq = (sel == 2);
                end else begin
                    id  = 3'(1 + $urandom % 6);
                    irq = tie ? 1'b0 : 1'($urandom % 2);
                end
                tag_mem[k] = mk_tag(irq, id, 16'($urandom % 40), {$urandom, 4'b0000} & 32'hFFFF_FFF0,
                                    {$urandom, $urandom});
            end
            pre = ($urandom % 3) == 0;
            if (pre)
                run(16'(1 + $urandom % 30), $urandom, 32'h0, 1'b1, 1'b1, 1'($urandom % 2), tie,
                    3'(1 + $urandom % 6), 1'b0, "R9 random preload");
            else
                run(16'd0, 32'h0, 32'h0, 1'b1, 1'($urandom % 2), 1'($urandom % 2), tie,
                    3'd0, 1'b0, "R3 random chain");
        end

        chk(fifo_level == 0, "R10 level zero when drained", 128'(fifo_level), 128'(0));
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule